// File: doc/BRIEF.md
# Presettable Decade Counter Digit

This block is one decimal digit of a synchronous counter. On every rising clock edge it either clears to zero, loads a four-bit value from its data input, steps to the next decimal value, or keeps its value. Clear and load are active-low. Stepping requires two active-high enables: a local one (`en_par`) and a carry-in (`en_carry`).

The `tc` output goes high while the digit sits at nine and the carry-in is high. To chain digits, connect a digit's `tc` to the carry-in of the next more significant digit and drive every digit from the same clock. Every higher digit then steps on the edge where all lower digits wrap. A whole digit chain can be preset, or cleared, on one edge. A user can shorten the count by feeding a decode of `q` back into the clear input.

Top module: `bcd_digit_ctr`

## Requirements
- R1: When `clr_n` is 0 at a rising edge, `q` becomes 0 after that edge, whatever the values of `ld_n`, `en_par` and `en_carry`.
- R2: When `clr_n` is 1 and `ld_n` is 0 at a rising edge, `q` takes the value of `din` after that edge, whatever the values of `en_par` and `en_carry`.
- R3: When `clr_n` and `ld_n` are both 1, `q` steps only if `en_par` and `en_carry` are both 1 at the edge. With any enable at 0, `q` keeps its value.
- R4: A step from a value 0 to 8 adds one, and a step from 9 gives 0.
- R5: `tc` is 1 exactly when `en_carry` is 1 and `q` equals 9 (binary 1001). It follows `en_carry` without waiting for a clock edge, and `en_par` has no effect on it.
- R6: With `en_carry` at 0, `tc` stays 0 even while `q` is 9.
- R7: If a value from 10 to 15 has been loaded, `tc` stays 0, and the next step sends `q` to 0.
- R8: `q` changes only at rising clock edges. Input changes between edges leave `q` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| clr_n | input | 1 | Synchronous clear, active low, highest priority |
| ld_n | input | 1 | Synchronous parallel load, active low |
| din | input | 4 | Value taken on load |
| en_par | input | 1 | Local count enable, active high |
| en_carry | input | 1 | Carry-in count enable, also gates `tc` |
| q | output | 4 | Current digit value |
| tc | output | 1 | Terminal count (nine with carry-in high) |

## Verification
Clear and load can be requested in the same cycle, and so can load and count. The bench provokes both cases by driving `clr_n` and `ld_n` low together with a nonzero `din`, and by loading with both enables high. It judges the results by the value `q` holds after the edge: zero when clear is present, `din` when only load is present, and never the incremented value. The bench also changes `en_carry` between edges while `q` is at nine. It confirms that `tc` follows at once and that `q` does not move until the next edge.

// File: rtl/bcd_digit_pkg.sv
package bcd_digit_pkg;

  localparam int DIGIT_W = 4;
  localparam logic [DIGIT_W-1:0] DIGIT_TOP = 4'd9;

  typedef enum logic [1:0] {
    OP_CLEAR = 2'd0,
    OP_LOAD  = 2'd1,
    OP_STEP  = 2'd2,
    OP_KEEP  = 2'd3
  } digit_op_t;

  // Successor in the decade ring; anything at or past the top returns to zero.
  function automatic logic [DIGIT_W-1:0] digit_succ(input logic [DIGIT_W-1:0] v);
    if (v >= DIGIT_TOP) digit_succ = '0;
    else                digit_succ = v + 1'b1;
  endfunction

  function automatic logic digit_is_top(input logic [DIGIT_W-1:0] v);
    digit_is_top = (v == DIGIT_TOP);
  endfunction

endpackage

// File: rtl/bcd_op_select.sv
module bcd_op_select
  import bcd_digit_pkg::*;
(
  input  logic      clr_n,
  input  logic      ld_n,
  input  logic      en_par,
  input  logic      en_carry,
  output digit_op_t op
);
  // Fixed priority: clear, load, step, keep.
  always_comb begin
    if (!clr_n)                 op = OP_CLEAR;
    else if (!ld_n)             op = OP_LOAD;
    else if (en_par && en_carry) op = OP_STEP;
    else                        op = OP_KEEP;
  end
endmodule

// File: rtl/bcd_next_value.sv
module bcd_next_value
  import bcd_digit_pkg::*;
#(
  parameter int W = DIGIT_W
) (
  input  digit_op_t      op,
  input  logic [W-1:0]   cur,
  input  logic [W-1:0]   din,
  output logic [W-1:0]   nxt
);
  always_comb begin
    unique case (op)
      OP_CLEAR: nxt = '0;
      OP_LOAD:  nxt = din;
      OP_STEP:  nxt = digit_succ(cur);
      default:  nxt = cur;
    endcase
  end
endmodule

// File: rtl/bcd_tc_decode.sv
module bcd_tc_decode
  import bcd_digit_pkg::*;
#(
  parameter int W = DIGIT_W
) (
  input  logic [W-1:0] cur,
  input  logic         en_carry,
  output logic         tc
);
  always_comb tc = en_carry && digit_is_top(cur);
endmodule

// File: rtl/bcd_digit_ctr.sv
module bcd_digit_ctr
  import bcd_digit_pkg::*;
#(
  parameter int W = DIGIT_W
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic         ld_n,
  input  logic [W-1:0] din,
  input  logic         en_par,
  input  logic         en_carry,
  output logic [W-1:0] q,
  output logic         tc
);
  digit_op_t    op_w;
  logic [W-1:0] nxt_w;
  logic [W-1:0] state_q;

  bcd_op_select u_sel (
    .clr_n    (clr_n),
    .ld_n     (ld_n),
    .en_par   (en_par),
    .en_carry (en_carry),
    .op       (op_w)
  );

  bcd_next_value #(.W(W)) u_nxt (
    .op  (op_w),
    .cur (state_q),
    .din (din),
    .nxt (nxt_w)
  );

  bcd_tc_decode #(.W(W)) u_tc (
    .cur      (state_q),
    .en_carry (en_carry),
    .tc       (tc)
  );

  always_ff @(posedge clk) state_q <= nxt_w;

  assign q = state_q;
endmodule

// File: rtl/bcd_digit_ctr_chk.sv
module bcd_digit_ctr_chk
  import bcd_digit_pkg::*;
#(
  parameter int W = DIGIT_W
) (
  input logic         clk,
  input logic         clr_n,
  input logic         ld_n,
  input logic [W-1:0] din,
  input logic         en_par,
  input logic         en_carry,
  input logic [W-1:0] q,
  input logic         tc
);
  // State is unknown until a first clear has been seen.
  logic primed = 1'b0;
  always_ff @(posedge clk) if (!clr_n) primed <= 1'b1;

  logic stepping;
  assign stepping = clr_n && ld_n && en_par && en_carry;

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!primed)
    !clr_n |=> (q == '0)); // R1
  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!primed)
    (clr_n && !ld_n) |=> (q == $past(din))); // R2
  AST_KEEP_IDLE: assert property (@(posedge clk) disable iff (!primed)
    (clr_n && ld_n && !(en_par && en_carry)) |=> $stable(q)); // R3
  AST_STEP_UP: assert property (@(posedge clk) disable iff (!primed)
    (stepping && q < 4'd9) |=> (q == $past(q) + 1'b1)); // R4
  AST_WRAP_NINE: assert property (@(posedge clk) disable iff (!primed)
    (stepping && q == 4'd9) |=> (q == '0)); // R4
  AST_TC_AT_NINE: assert property (@(posedge clk) disable iff (!primed)
    tc |-> (q == 4'd9)); // R5
  AST_TC_NEEDS_CARRY: assert property (@(posedge clk) disable iff (!primed)
    tc |-> en_carry); // R6
  AST_OOR_RETURN: assert property (@(posedge clk) disable iff (!primed)
    (stepping && q > 4'd9) |=> (q == '0)); // R7
endmodule

bind bcd_digit_ctr bcd_digit_ctr_chk #(.W(W)) u_chk (
  .clk      (clk),
  .clr_n    (clr_n),
  .ld_n     (ld_n),
  .din      (din),
  .en_par   (en_par),
  .en_carry (en_carry),
  .q        (q),
  .tc       (tc)
);

// File: tb/bcd_digit_ctr_tb.sv
module bcd_digit_ctr_tb;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       clr_n = 1'b1, ld_n = 1'b1, en_par = 1'b0, en_carry = 1'b0;
  logic [3:0] din = '0;
  logic [3:0] q;
  logic       tc;
  int         n_chk = 0, n_fail = 0;
  logic [3:0] exp_q = '0;

  always #(CLK_P/2) clk = ~clk;

  bcd_digit_ctr u_dut (
    .clk(clk), .clr_n(clr_n), .ld_n(ld_n), .din(din),
    .en_par(en_par), .en_carry(en_carry), .q(q), .tc(tc)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Independent model of the next value, written from the requirements.
  function automatic logic [3:0] model(input logic c, l, p, e, input logic [3:0] d, cur);
    if (!c) return 4'd0;
    if (!l) return d;
    if (p && e) return (cur == 4'd9 || cur > 4'd9) ? 4'd0 : cur + 4'd1;
    return cur;
  endfunction

  function automatic int exp_tc();
    return (en_carry && exp_q == 4'd9) ? 1 : 0;
  endfunction

  // Apply inputs, take one edge, sample a quarter period later.
  task automatic tick(input logic c, l, p, e, input logic [3:0] d);
    clr_n = c; ld_n = l; en_par = p; en_carry = e; din = d;
    exp_q = model(c, l, p, e, d, exp_q);
    @(posedge clk);
    #(CLK_P/4);
  endtask

  task automatic t_reset();
    tick(1'b0, 1'b1, 1'b1, 1'b1, 4'd5);
    check("R1 clear", q, 0);
    check("R5 tc after clear", tc, 0);
  endtask

  task automatic t_load_idle();
    for (int v = 0; v < 10; v++) begin
      tick(1'b1, 1'b0, 1'b0, 1'b0, v[3:0]);
      check("R2 load enables low", q, v);
    end
    tick(1'b1, 1'b0, 1'b1, 1'b1, 4'd3);
    check("R2 load beats step", q, 3);
  endtask

  task automatic t_count();
    tick(1'b1, 1'b0, 1'b0, 1'b0, 4'd0);
    for (int i = 0; i < 13; i++) begin
      check("R5 tc while counting", tc, exp_tc());
      tick(1'b1, 1'b1, 1'b1, 1'b1, 4'd0);
      check("R4 decade step", q, exp_q);
    end
  endtask

  task automatic t_keep();
    tick(1'b1, 1'b0, 1'b0, 1'b0, 4'd4);
    tick(1'b1, 1'b1, 1'b0, 1'b1, 4'd0);
    check("R3 keep en_par low", q, 4);
    tick(1'b1, 1'b1, 1'b1, 1'b0, 4'd0);
    check("R3 keep en_carry low", q, 4);
    tick(1'b1, 1'b1, 1'b0, 1'b0, 4'd0);
    check("R3 keep both low", q, 4);
  endtask

  task automatic t_clear_load();
    tick(1'b1, 1'b0, 1'b0, 1'b0, 4'd6);
    tick(1'b0, 1'b0, 1'b1, 1'b1, 4'd7);
    check("R1 clear beats load", q, 0);
  endtask

  task automatic t_tc_gate();
    tick(1'b1, 1'b0, 1'b0, 1'b1, 4'd9);
    check("R5 tc at nine en_par low", tc, 1);
    en_carry = 1'b0; #1;
    check("R6 tc drops with carry", tc, 0);
    en_carry = 1'b1; #1;
    check("R5 tc follows carry", tc, 1);
    clr_n = 1'b0; ld_n = 1'b0; din = 4'd2; #1;
    check("R8 no change between edges", q, 9);
    clr_n = 1'b1; ld_n = 1'b1; en_par = 1'b0; en_carry = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_out_of_range();
    for (int v = 10; v < 16; v++) begin
      tick(1'b1, 1'b0, 1'b0, 1'b1, v[3:0]);
      check("R7 loaded value", q, v);
      check("R7 tc low out of range", tc, 0);
      tick(1'b1, 1'b1, 1'b1, 1'b1, 4'd0);
      check("R7 step to zero", q, 0);
    end
  endtask

  initial begin
    #(CLK_P * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_load_idle();
    t_count();
    t_keep();
    t_clear_load();
    t_tc_gate();
    t_out_of_range();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule